// File: doc/BRIEF.md
# Reset Configuration Word Fetcher

This block runs once after a hard reset. It reads the configuration words for a processor and for up to seven secondary devices out of a boot memory. It uses a simple byte-read interface that carries one request at a time. The boot memory returns a bus-wide data word, and the block keeps only its lowest byte, so the width of the boot device does not matter.

The block makes 32 reads at addresses spaced 8 apart. Each run of four bytes is packed into one 32-bit word, with the first byte in the most significant position. Word 0 belongs to the local processor. Words 1 to 7 belong to secondary slots 1 to 7, and each of these slots carries its own valid flag. When the last byte has been captured, the block raises a done flag and freezes every output until the next reset.

The block also publishes the first instruction fetch address. A parameterised prefix bit in the local word picks the base, either all zeros or 0xFFF00000. The block adds the fixed exception offset 0x100 to that base.

Top module: `cfgfetch_top`

## Requirements
- R1: After reset the block issues exactly 32 byte-read requests. Once the 32nd byte has been captured, `rdReq` stays low until the next reset.
- R2: Read number n (counting from 0) uses address n*8, so the first read is at address 0 and each later address is 8 above the one before.
- R3: A read keeps only bits [7:0] of `rdData`. All higher lanes of the data bus have no effect on any output.
- R4: Reads 4k to 4k+3 form word k. Read 4k lands in bits [31:24], read 4k+1 in bits [23:16], read 4k+2 in bits [15:8] and read 4k+3 in bits [7:0].
- R5: Word 0 appears on `masterWord`. Word j, for j from 1 to 7, appears on `slaveWords[32*j-1:32*(j-1)]`.
- R6: `slaveValid[j-1]` rises at the clock edge that captures read 4j+3. Once set, it stays set until reset.
- R7: `done` rises at the clock edge that captures read 31 and not before. After that, `done` and every word, valid and vector output hold steady until reset.
- R8: Only one read is outstanding at a time. While `rdReq` is high and `rdValid` is low, `rdAddr` holds its value. An `rdValid` pulse that arrives while `rdReq` is low changes nothing.
- R9: `bootVector` reads 0 until `done` is set. After that it reads 0x00000100 when bit CIP_BIT (default 16) of the local word is 0, and 0xFFF00100 when that bit is 1.
- R10: While reset is applied, and in the first cycle after it is released, `rdReq`, `done`, `slaveValid`, `bootVector` and all word outputs are 0.
- R11: The assembled words do not depend on how many cycles the memory waits before it asserts `rdValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdReq | output | 1 | Read request, held high until the data handshake completes |
| rdAddr | output | 32 | Byte address of the current read |
| rdData | input | 32 | Returned data; only bits [7:0] are used |
| rdValid | input | 1 | Marks `rdData` as valid for the current request |
| masterWord | output | 32 | Assembled word for the local processor |
| slaveWords | output | 224 | Words for slots 1 to 7; slot j occupies bits [32j-1:32(j-1)] |
| slaveValid | output | 7 | Bit j-1 is set once all four bytes of slot j have been captured |
| done | output | 1 | Set once all 32 bytes have been captured |
| bootVector | output | 32 | First fetch address: the selected base plus 0x100 |

## Verification
The state that matters is the byte counter. If it is wrong, the addresses on `rdAddr` drift off the stride of 8 at the very next request, and the bench checks every address as it is issued. A wrong byte-lane decode shows up as swapped bytes in the affected word, or as a slot valid flag that rises at the wrong count. The bench compares the valid flags before every read, so such a fault is visible within one word, that is, four reads. A done or vector fault shows up in the cycle right after the final capture, because the bench samples `done`, `bootVector` and `rdReq` there.

// File: rtl/cfgfetch_pkg.sv
package cfgfetch_pkg;
  localparam int CFG_WORDS      = 8;
  localparam int CFG_WORD_BYTES = 4;
  localparam int CFG_TOTAL      = CFG_WORDS * CFG_WORD_BYTES;
  localparam int CFG_SLOT_W     = $clog2(CFG_TOTAL);
  localparam int CFG_WORD_W     = CFG_WORD_BYTES * 8;

  typedef struct packed {
    logic                  capture;
    logic                  finish;
    logic                  done;
    logic [CFG_SLOT_W-1:0] slot;
  } fetchStrobe_t;
endpackage

// File: rtl/cfgfetch_ctrl.sv
module cfgfetch_ctrl
  import cfgfetch_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BYTE_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdValid,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output fetchStrobe_t      strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DONE} fetchState_e;

  fetchState_e           state;
  logic [CFG_SLOT_W-1:0] byteIdx;
  logic                  take;
  logic                  lastByte;

  assign rdReq    = (state == ST_FETCH);
  assign take     = rdReq && rdValid;
  assign lastByte = (byteIdx == CFG_SLOT_W'(CFG_TOTAL - 1));
  assign rdAddr   = ADDR_W'(byteIdx) * ADDR_W'(BYTE_STRIDE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteIdx <= '0;
    end else begin
      case (state)
        ST_IDLE:  state <= ST_FETCH;
        ST_FETCH: if (take) begin
          if (lastByte) state <= ST_DONE;
          else          byteIdx <= byteIdx + 1'b1;
        end
        default:  state <= ST_DONE;
      endcase
    end
  end

  always_comb begin
    strb.capture = take;
    strb.finish  = take && lastByte;
    strb.done    = (state == ST_DONE);
    strb.slot    = byteIdx;
  end

  // R1
  done_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |-> !rdReq);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (take && !lastByte) |=> (rdAddr == $past(rdAddr) + ADDR_W'(BYTE_STRIDE)));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid) |=> (rdReq && $stable(rdAddr)));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> strb.done);
endmodule

// File: rtl/cfgfetch_dpath.sv
module cfgfetch_dpath
  import cfgfetch_pkg::*;
#(
  parameter int                BUS_W      = 32,
  parameter int                ADDR_W     = 32,
  parameter int                CIP_BIT    = 16,
  parameter logic [ADDR_W-1:0] HIGH_BASE  = 32'hFFF0_0000,
  parameter int                VEC_OFFSET = 32'h100
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  fetchStrobe_t                          strb,
  input  logic [BUS_W-1:0]                      rdData,
  output logic [CFG_WORD_W-1:0]                 masterWord,
  output logic [(CFG_WORDS-1)*CFG_WORD_W-1:0]   slaveWords,
  output logic [CFG_WORDS-2:0]                  slaveValid,
  output logic [ADDR_W-1:0]                     bootVector
);
  localparam int BSEL_W = $clog2(CFG_WORD_BYTES);
  localparam int WSEL_W = CFG_SLOT_W - BSEL_W;
  localparam int LSB_W  = $clog2(CFG_WORD_W);

  logic [7:0]                            byteIn;
  logic [WSEL_W-1:0]                     wordSel;
  logic [BSEL_W-1:0]                     byteSel;
  logic [LSB_W-1:0]                      laneLsb;
  logic [CFG_WORDS-1:0][CFG_WORD_W-1:0]  bankArr;

  assign byteIn  = rdData[7:0];
  assign wordSel = strb.slot[CFG_SLOT_W-1:BSEL_W];
  assign byteSel = strb.slot[BSEL_W-1:0];
  assign laneLsb = LSB_W'((CFG_WORD_BYTES - 1 - int'(byteSel)) * 8);

  for (genvar w = 0; w < CFG_WORDS; w++) begin : g_word
    logic [CFG_WORD_W-1:0] wordReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        wordReg <= '0;
      else if (strb.capture && wordSel == WSEL_W'(w))
        wordReg[laneLsb +: 8] <= byteIn;
    end
    assign bankArr[w] = wordReg;

    if (w > 0) begin : g_slave
      logic validReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          validReg <= 1'b0;
        else if (strb.capture && wordSel == WSEL_W'(w) &&
                 byteSel == BSEL_W'(CFG_WORD_BYTES - 1))
          validReg <= 1'b1;
      end
      assign slaveValid[w-1] = validReg;
      assign slaveWords[(w-1)*CFG_WORD_W +: CFG_WORD_W] = wordReg;
    end
  end

  assign masterWord = bankArr[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      bootVector <= '0;
    else if (strb.finish)
      bootVector <= (bankArr[0][CIP_BIT] ? HIGH_BASE : '0) + ADDR_W'(VEC_OFFSET);
  end

  // R7
  frozen_words_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> ($stable(bankArr) && $stable(bootVector) && $stable(slaveValid)));

  // R6
  valid_monotone_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slaveValid != '0) |=> ((slaveValid & $past(slaveValid)) == $past(slaveValid)));

  // R9
  vector_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.done && !strb.finish) |=> (bootVector == '0 || strb.done));
endmodule

// File: rtl/cfgfetch_top.sv
module cfgfetch_top
  import cfgfetch_pkg::*;
#(
  parameter int                BUS_W       = 32,
  parameter int                ADDR_W      = 32,
  parameter int                BYTE_STRIDE = 8,
  parameter int                CIP_BIT     = 16,
  parameter logic [ADDR_W-1:0] HIGH_BASE   = 32'hFFF0_0000,
  parameter int                VEC_OFFSET  = 32'h100
) (
  input  logic                                clk,
  input  logic                                rstN,
  output logic                                rdReq,
  output logic [ADDR_W-1:0]                   rdAddr,
  input  logic [BUS_W-1:0]                    rdData,
  input  logic                                rdValid,
  output logic [CFG_WORD_W-1:0]               masterWord,
  output logic [(CFG_WORDS-1)*CFG_WORD_W-1:0] slaveWords,
  output logic [CFG_WORDS-2:0]                slaveValid,
  output logic                                done,
  output logic [ADDR_W-1:0]                   bootVector
);
  fetchStrobe_t strb;

  cfgfetch_ctrl #(
    .ADDR_W(ADDR_W), .BYTE_STRIDE(BYTE_STRIDE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .rdValid(rdValid),
    .rdReq(rdReq), .rdAddr(rdAddr), .strb(strb)
  );

  cfgfetch_dpath #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .CIP_BIT(CIP_BIT),
    .HIGH_BASE(HIGH_BASE), .VEC_OFFSET(VEC_OFFSET)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdData(rdData),
    .masterWord(masterWord), .slaveWords(slaveWords),
    .slaveValid(slaveValid), .bootVector(bootVector)
  );

  assign done = strb.done;
endmodule

// File: tb/cfgfetch_top_tb_top.sv
module cfgfetch_top_tb_top;
  localparam int CIP_BIT  = 16;
  localparam int CIP_ADDR = (3 - CIP_BIT / 8) * 8;

  // scenario: [15:12] wait cycles, [8] prefix bit, [7:0] seed
  localparam logic [15:0] SCEN [5] = '{16'h003C, 16'h115A, 16'h30A7, 16'h2101, 16'h01F0};

  logic         clk = 1'b0;
  logic         rstN;
  logic         rdReq;
  logic [31:0]  rdAddr;
  logic [31:0]  rdData;
  logic         rdValid;
  logic [31:0]  masterWord;
  logic [223:0] slaveWords;
  logic [6:0]   slaveValid;
  logic         done;
  logic [31:0]  bootVector;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2 clk = ~clk;

  cfgfetch_top #(.CIP_BIT(CIP_BIT)) dut_i (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdData(rdData), .rdValid(rdValid), .masterWord(masterWord),
    .slaveWords(slaveWords), .slaveValid(slaveValid), .done(done),
    .bootVector(bootVector)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    summary();
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] memByte(input logic [7:0] seed, input logic cip, input int addr);
    logic [7:0] b;
    b = seed ^ 8'((addr / 8) * 29 + 7);
    if (addr == CIP_ADDR) b[CIP_BIT % 8] = cip;
    return b;
  endfunction

  function automatic logic [31:0] expWord(input logic [7:0] seed, input logic cip, input int k);
    return {memByte(seed, cip, (4*k)*8), memByte(seed, cip, (4*k+1)*8),
            memByte(seed, cip, (4*k+2)*8), memByte(seed, cip, (4*k+3)*8)};
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    rdValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic checkResetState(input string tag);
    chk(rdReq == 1'b0, {tag, " R10 rdReq"}, 32'(rdReq), 32'd0);
    chk(done == 1'b0 && slaveValid == '0, {tag, " R10 done/valid"}, {24'd0, slaveValid, done}, 32'd0);
    chk(masterWord == '0 && slaveWords == '0, {tag, " R10 words"}, masterWord, 32'd0);
    chk(bootVector == '0, {tag, " R10 vector"}, bootVector, 32'd0);
  endtask

  task automatic runFetch(input logic [7:0] seed, input logic cip, input int lat, input int limit);
    int reads = 0;
    bit addrBad = 0;
    bit validBad = 0;
    bit earlyBad = 0;
    logic [31:0] badAddr = '0;
    logic [6:0] expValid;
    while (reads < limit) begin
      @(negedge clk);
      rdValid = 1'b0;
      if (rdReq) begin
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          if (!rdReq || rdAddr != 32'(reads * 8)) addrBad = 1; // R8
        end
        if (rdAddr != 32'(reads * 8)) begin addrBad = 1; badAddr = rdAddr; end // R2
        for (int j = 1; j < 8; j++) expValid[j-1] = (reads >= 4*j + 4);
        if (slaveValid != expValid) validBad = 1; // R6
        if (done || bootVector != '0) earlyBad = 1; // R7 R9
        rdData  = {8'hC3 ^ seed, 8'h5A, 8'hFF, memByte(seed, cip, reads * 8)}; // R3 upper lanes noise
        rdValid = 1'b1;
        reads++;
      end
    end
    chk(!addrBad, "R2 R8 address sequence", badAddr, 32'(reads * 8));
    chk(!validBad, "R6 slot valid progress", {25'd0, slaveValid}, {25'd0, expValid});
    chk(!earlyBad, "R7 R9 nothing before last byte", {31'd0, done}, 32'd0);
    if (limit == 32) begin
      @(negedge clk);
      rdValid = 1'b0;
      chk(done == 1'b1, "R7 done after 32nd byte", 32'(done), 32'd1);
      chk(rdReq == 1'b0, "R1 request drops", 32'(rdReq), 32'd0);
      chk(masterWord == expWord(seed, cip, 0), "R4 R5 R3 R11 master word", masterWord, expWord(seed, cip, 0));
      for (int j = 1; j < 8; j++)
        chk(slaveWords[(j-1)*32 +: 32] == expWord(seed, cip, j), "R4 R5 R11 slave word",
            slaveWords[(j-1)*32 +: 32], expWord(seed, cip, j));
      chk(slaveValid == 7'h7F, "R6 all slots valid", {25'd0, slaveValid}, 32'h7F);
      chk(bootVector == (cip ? 32'hFFF0_0100 : 32'h0000_0100), "R9 boot vector",
          bootVector, cip ? 32'hFFF0_0100 : 32'h0000_0100);
      repeat (4) @(negedge clk);
      chk(rdReq == 1'b0 && done == 1'b1, "R1 no further reads", {30'd0, rdReq, done}, 32'd1);
    end
  endtask

  initial begin
    logic [31:0]  snapMaster;
    logic [223:0] snapSlaves;
    logic [31:0]  snapVec;
    rstN = 1'b0;
    rdValid = 1'b0;
    rdData = '0;
    repeat (2) @(negedge clk);
    checkResetState("in reset");
    rstN = 1'b1;
    checkResetState("first cycle"); // R10
    // R8: stray handshake while no request is pending
    rdValid = 1'b1;
    rdData = 32'hFFFF_FFFF;
    @(negedge clk);
    rdValid = 1'b0;
    runFetch(8'h3C, 1'b0, 0, 32);

    // R7 R8: handshakes after completion change nothing
    snapMaster = masterWord;
    snapSlaves = slaveWords;
    snapVec = bootVector;
    for (int i = 0; i < 3; i++) begin
      rdValid = 1'b1;
      rdData = 32'h1234_5600 + 32'(i);
      @(negedge clk);
    end
    rdValid = 1'b0;
    @(negedge clk);
    chk(masterWord == snapMaster && slaveWords == snapSlaves, "R7 R8 words frozen", masterWord, snapMaster);
    chk(bootVector == snapVec && done && !rdReq, "R7 vector frozen", bootVector, snapVec);

    // stimulus table
    for (int s = 0; s < 5; s++) begin
      doReset();
      runFetch(SCEN[s][7:0], SCEN[s][8], int'(SCEN[s][15:12]), 32);
    end

    // R10: reset part way through a fetch, then refetch cleanly
    doReset();
    runFetch(8'h77, 1'b1, 1, 10);
    @(negedge clk);
    rstN = 1'b0;
    rdValid = 1'b0;
    #1;
    checkResetState("mid-fetch reset");
    @(negedge clk);
    rstN = 1'b1;
    runFetch(8'h77, 1'b1, 2, 32);

    summary();
  end
endmodule